// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block carries one 8-bit PCM sample per frame in each direction between parallel registers and a time-division serial backplane. The bit clock drives it. A frame sync pulse or square wave at the 8 kHz frame rate aligns it. Transmit bits leave on rising bit-clock edges and receive bits are taken on falling edges. The transmit slot and the receive slot are configured separately: each has a 6-bit slot number, a bit that picks one of two ports, and an enable bit.

There are two timing modes. In direct mode the frame sync itself marks the slot, so the slot numbers are ignored. In counted mode the frame sync marks the frame start, and a bit-position counter places slot N at bit period 1 + 8·N after the sync. On the selected port the block raises a per-port output enable, which stands in for the tristate control. It also pulls low an active-low indicator that can gate an external line driver. A received byte is presented in parallel together with a one-cycle strobe.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, both output enables are low, both active-low slot indicators are high and the receive strobe is low.
- R2: In direct mode (`delayed_mode`=0), both slots start in the bit period that begins at the first rising edge where frame sync is sampled high after having been low. A frame sync held high for several periods starts only one slot. The slot number inputs have no effect.
- R3: In counted mode (`delayed_mode`=1), slot N starts in the bit period that begins 1 + 8·N rising edges after the edge where frame sync is first sampled high.
- R4: The transmit byte is sent MSB first, one bit per period for 8 periods, updated on rising edges, on port `tx_port_sel` (0 selects index 0, 1 selects index 1).
- R5: `tx_drive[p]` is high only during the transmit slot and only for the selected port p. `tx_slot_n[p]` is low exactly while `tx_drive[p]` is high.
- R6: The transmit byte is captured in the first bit period of the slot. Changes to `tx_byte` later in the slot do not affect the bits sent.
- R7: Receive bits are sampled on falling edges from `rx_bit[rx_port_sel]` during the 8 periods of the receive slot, MSB first.
- R8: `rx_strobe` is high for exactly one bit-clock period, starting at the falling edge that samples the eighth bit. `rx_byte` then shows the assembled byte and holds it until the next complete slot.
- R9: With `tx_enable` low no output enable is raised. With `rx_enable` low no strobe is issued and `rx_byte` keeps its value.
- R10: Receive inputs outside the receive slot, and on the unselected port, do not affect `rx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync |
| delayed_mode | input | 1 | 1 = counted slot placement, 0 = direct |
| tx_slot_sel | input | 6 | Transmit slot number (counted mode) |
| tx_port_sel | input | 1 | Transmit port select |
| tx_enable | input | 1 | Transmit slot enable |
| rx_slot_sel | input | 6 | Receive slot number (counted mode) |
| rx_port_sel | input | 1 | Receive port select |
| rx_enable | input | 1 | Receive slot enable |
| tx_byte | input | 8 | Parallel transmit sample |
| tx_bit | output | 2 | Serial transmit data per port (valid when driven) |
| tx_drive | output | 2 | Per-port transmit output enable |
| tx_slot_n | output | 2 | Per-port active-low slot indicator |
| rx_bit | input | 2 | Serial receive data per port |
| rx_byte | output | 8 | Last received sample |
| rx_strobe | output | 1 | One-period strobe for a new received sample |

## Verification
The embedded assertions check the invariants that hold on every cycle. At most one port is driven at a time. A disabled direction raises no enable and no receive activity. Each strobe lasts one period. The position counter restarts on a direct-mode sync and parks once the frame has run out. Only the bench scenarios can show the slot placement in both modes, the bit order on each port, late changes to the transmit byte, receive noise outside the slot and on the other port, and a sync held high for several periods. The bench checks these against timings it works out itself.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
    localparam int SLOT_W = 6;
    localparam int BYTE_W = 8;
    localparam int PORTS  = 2;
    localparam int PORT_W = $clog2(PORTS);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int POS_W  = SLOT_W + BIT_W + 1;

    localparam logic [POS_W-1:0] POS_IDLE = {1'b1, {(POS_W-1){1'b0}}};
    localparam logic [POS_W-1:0] POS_PRE  = {POS_W{1'b1}};
    localparam logic [BIT_W-1:0] BIT_LAST = {BIT_W{1'b1}};

    function automatic logic in_slot(input logic [POS_W-1:0] pos,
                                     input logic [SLOT_W-1:0] slot,
                                     input logic dly);
        logic [SLOT_W-1:0] eff;
        eff = dly ? slot : '0;
        return !pos[POS_W-1] && (pos[POS_W-2:BIT_W] == eff);
    endfunction
endpackage

// File: rtl/pcm_frame_pos.sv
module pcm_frame_pos
    import pcm_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             delayed,
    output logic [POS_W-1:0] pos_next
);
    typedef struct packed {
        logic             fs;
        logic [POS_W-1:0] pos;
    } pos_st_t;

    pos_st_t s_q, s_d;
    logic    fs_rise;

    always_comb begin
        s_d     = s_q;
        fs_rise = fsync && !s_q.fs;
        s_d.fs  = fsync;
        if (fs_rise)
            s_d.pos = delayed ? POS_PRE : '0;
        else if (s_q.pos != POS_IDLE)
            s_d.pos = s_q.pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{fs: 1'b0, pos: POS_IDLE};
        else        s_q <= s_d;
    end

    assign pos_next = s_d.pos;

    assert_direct_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !s_q.fs && !delayed) |=> (s_q.pos == '0));

    assert_idle_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pos == POS_IDLE && !(fsync && !s_q.fs)) |=> (s_q.pos == POS_IDLE));
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos_next,
    input  logic              delayed,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic [PORT_W-1:0] port_sel,
    input  logic              enable,
    input  logic [BYTE_W-1:0] par_byte,
    output logic [PORTS-1:0]  ser_bit,
    output logic [PORTS-1:0]  drive,
    output logic [PORTS-1:0]  slot_n
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [PORTS-1:0]  drv;
    } tx_st_t;

    tx_st_t s_q, s_d;
    logic   hit_d, start_d;

    always_comb begin
        s_d     = s_q;
        hit_d   = enable && in_slot(pos_next, slot_sel, delayed);
        start_d = hit_d && (pos_next[BIT_W-1:0] == '0);
        if (start_d)
            s_d.sh = par_byte;
        else if (hit_d)
            s_d.sh = {s_q.sh[BYTE_W-2:0], 1'b0};
        for (int p = 0; p < PORTS; p++)
            s_d.drv[p] = hit_d && (port_sel == PORT_W'(p));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign ser_bit[p] = s_q.sh[BYTE_W-1] & s_q.drv[p];
        assign drive[p]   = s_q.drv[p];
        assign slot_n[p]  = ~s_q.drv[p];
    end

    assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive));

    assert_tx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (drive == '0));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos_next,
    input  logic              delayed,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic [PORT_W-1:0] port_sel,
    input  logic              enable,
    input  logic [PORTS-1:0]  ser_bit,
    output logic [BYTE_W-1:0] par_byte,
    output logic              strobe
);
    typedef struct packed {
        logic              act;
        logic              last;
        logic [PORT_W-1:0] port;
    } rx_ctl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] hold;
        logic              stb;
    } rx_dat_t;

    rx_ctl_t c_q, c_d;
    rx_dat_t d_q, d_d;
    logic    in_bit;

    always_comb begin
        c_d      = c_q;
        c_d.act  = enable && in_slot(pos_next, slot_sel, delayed);
        c_d.last = c_d.act && (pos_next[BIT_W-1:0] == BIT_LAST);
        c_d.port = port_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        d_d     = d_q;
        in_bit  = ser_bit[c_q.port];
        d_d.stb = 1'b0;
        if (c_q.act) begin
            d_d.sh = {d_q.sh[BYTE_W-2:0], in_bit};
            if (c_q.last) begin
                d_d.hold = {d_q.sh[BYTE_W-2:0], in_bit};
                d_d.stb  = 1'b1;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign par_byte = d_q.hold;
    assign strobe   = d_q.stb;

    assert_strobe_single_R8: assert property (@(negedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    assert_rx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !c_q.act);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_slot_pkg::*;
(
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              delayed_mode,
    input  logic [SLOT_W-1:0] tx_slot_sel,
    input  logic [PORT_W-1:0] tx_port_sel,
    input  logic              tx_enable,
    input  logic [SLOT_W-1:0] rx_slot_sel,
    input  logic [PORT_W-1:0] rx_port_sel,
    input  logic              rx_enable,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [PORTS-1:0]  tx_bit,
    output logic [PORTS-1:0]  tx_drive,
    output logic [PORTS-1:0]  tx_slot_n,
    input  logic [PORTS-1:0]  rx_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_strobe
);
    logic [POS_W-1:0] pos_next;

    pcm_frame_pos u_pos (
        .clk      (bclk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .delayed  (delayed_mode),
        .pos_next (pos_next)
    );

    pcm_tx_slot u_tx (
        .clk      (bclk),
        .rst_n    (rst_n),
        .pos_next (pos_next),
        .delayed  (delayed_mode),
        .slot_sel (tx_slot_sel),
        .port_sel (tx_port_sel),
        .enable   (tx_enable),
        .par_byte (tx_byte),
        .ser_bit  (tx_bit),
        .drive    (tx_drive),
        .slot_n   (tx_slot_n)
    );

    pcm_rx_slot u_rx (
        .clk      (bclk),
        .rst_n    (rst_n),
        .pos_next (pos_next),
        .delayed  (delayed_mode),
        .slot_sel (rx_slot_sel),
        .port_sel (rx_port_sel),
        .enable   (rx_enable),
        .ser_bit  (rx_bit),
        .par_byte (rx_byte),
        .strobe   (rx_strobe)
    );
endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
    logic       bclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       delayed_mode = 1'b0;
    logic [5:0] tx_slot_sel = '0;
    logic       tx_port_sel = 1'b0;
    logic       tx_enable = 1'b0;
    logic [5:0] rx_slot_sel = '0;
    logic       rx_port_sel = 1'b0;
    logic       rx_enable = 1'b0;
    logic [7:0] tx_byte = '0;
    logic [1:0] tx_bit, tx_drive, tx_slot_n;
    logic [1:0] rx_bit = '0;
    logic [7:0] rx_byte;
    logic       rx_strobe;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_rx = 8'h00;

    always #5 bclk = ~bclk;

    pcm_slot_port u_dut (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .delayed_mode(delayed_mode),
        .tx_slot_sel(tx_slot_sel), .tx_port_sel(tx_port_sel), .tx_enable(tx_enable),
        .rx_slot_sel(rx_slot_sel), .rx_port_sel(rx_port_sel), .rx_enable(rx_enable),
        .tx_byte(tx_byte), .tx_bit(tx_bit), .tx_drive(tx_drive), .tx_slot_n(tx_slot_n),
        .rx_bit(rx_bit), .rx_byte(rx_byte), .rx_strobe(rx_strobe)
    );

    typedef struct packed {
        logic       dly;
        logic [5:0] ts;
        logic       tp;
        logic [5:0] rs;
        logic       rp;
        logic [7:0] tb;
        logic [7:0] rb;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{dly: 1'b0, ts: 6'd0,  tp: 1'b0, rs: 6'd0,  rp: 1'b0, tb: 8'hA5, rb: 8'h3C},
        '{dly: 1'b0, ts: 6'd9,  tp: 1'b1, rs: 6'd17, rp: 1'b1, tb: 8'h81, rb: 8'h7E},
        '{dly: 1'b1, ts: 6'd0,  tp: 1'b0, rs: 6'd2,  rp: 1'b1, tb: 8'hC3, rb: 8'h96},
        '{dly: 1'b1, ts: 6'd5,  tp: 1'b1, rs: 6'd5,  rp: 1'b0, tb: 8'h01, rb: 8'h80},
        '{dly: 1'b1, ts: 6'd63, tp: 1'b0, rs: 6'd62, rp: 1'b1, tb: 8'hFF, rb: 8'h5A},
        '{dly: 1'b1, ts: 6'd1,  tp: 1'b1, rs: 6'd0,  rp: 1'b0, tb: 8'h6D, rb: 8'hB2}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge bclk);
        #2;
    endtask

    // One frame: sync raised for fs_len periods, then 520 bit periods observed.
    task automatic run_frame(input vec_t v, input int fs_len, input logic ten, input logic ren);
        int tstart, rstart;
        logic [7:0] orig;
        delayed_mode = v.dly;
        tx_slot_sel = v.ts; tx_port_sel = v.tp; tx_enable = ten;
        rx_slot_sel = v.rs; rx_port_sel = v.rp; rx_enable = ren;
        tx_byte = v.tb; orig = v.tb;
        tstart = v.dly ? 1 + 8 * int'(v.ts) : 0;
        rstart = v.dly ? 1 + 8 * int'(v.rs) : 0;
        step(); step();
        fsync = 1'b1;
        step();
        for (int i = 0; i < 520; i++) begin
            logic in_rx, in_tx, exp_drv, exp_stb;
            fsync = (i < fs_len - 1);
            in_rx = (i >= rstart) && (i < rstart + 8);
            in_tx = (i >= tstart) && (i < tstart + 8);
            // R6: change the parallel byte part-way through the slot
            if (i == tstart + 3) tx_byte = ~orig;
            // R10: noise outside the slot and on the other port
            rx_bit[v.rp]  = in_rx ? v.rb[7 - (i - rstart)] : i[0];
            rx_bit[!v.rp] = in_rx ? ~v.rb[7 - (i - rstart)] : ~i[0];
            #5;
            for (int p = 0; p < 2; p++) begin
                exp_drv = ten && in_tx && (v.tp == p[0]);
                chk(v.dly ? "R3/R5" : "R2/R5", "tx_drive", {7'd0, tx_drive[p]}, {7'd0, exp_drv});
                chk("R5", "tx_slot_n", {7'd0, tx_slot_n[p]}, {7'd0, !exp_drv});
                if (exp_drv)
                    chk("R4/R6", "tx_bit", {7'd0, tx_bit[p]}, {7'd0, orig[7 - (i - tstart)]});
            end
            exp_stb = ren && (i == rstart + 7);
            chk(ren ? "R8" : "R9", "rx_strobe", {7'd0, rx_strobe}, {7'd0, exp_stb});
            if (exp_stb) chk("R7/R10", "rx_byte", rx_byte, v.rb);
            step();
        end
        if (ren) last_rx = v.rb;
        chk("R8/R9", "rx_byte hold", rx_byte, last_rx);
        tx_byte = orig;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3;
        // R1: reset state
        chk("R1", "tx_drive", {6'd0, tx_drive}, 8'h00);
        chk("R1", "tx_slot_n", {6'd0, tx_slot_n}, 8'h03);
        chk("R1", "rx_strobe", {7'd0, rx_strobe}, 8'h00);
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1", "tx_drive after release", {6'd0, tx_drive}, 8'h00);

        // Table walk: R2, R3, R4, R5, R6, R7, R8, R10
        for (int n = 0; n < NV; n++) run_frame(VECS[n], 1, 1'b1, 1'b1);

        // R2: sync held high as a square wave starts one slot only
        run_frame(VECS[0], 4, 1'b1, 1'b1);

        // R9: both directions disabled, rx_byte keeps the last value
        run_frame(VECS[3], 1, 1'b0, 1'b0);

        // R9: only transmit disabled, receive still works
        run_frame(VECS[5], 1, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule